// File: doc/BRIEF.md
# USB OTG Status Tracker

This block keeps a 16-bit OTG status word current from two level indications that a USB core provides: whether VBUS is valid and whether a session is active. Both levels cross into the local clock domain through a multi-flop synchronizer. The status word is then updated from the synchronized levels.

When the VBUS-valid bit actually changes value, the block emits a single-cycle pulse. A neighbouring interrupt aggregator uses this pulse to set its VBUS-sense-change bit, which is bit 15 of that aggregator's main source word. Session indications drive a complementary pair of status bits and never produce a pulse.

Software samples the status word through a read strobe. The strobe captures a snapshot that stays on the read-data output until the next strobe.

Top module: `otg_status_tracker`

## Requirements
- R1: While reset is asserted and just after it is released, the status word, the change pulse and the read data are all zero. Status bit 3, the ID status bit, is zero, which means host mode.
- R2: Status bit 5 takes the value of the VBUS-valid input. It updates on the third rising clock edge after the input changes: two synchronizer flops, then the status register.
- R3: The change pulse goes high for exactly one cycle, in the same cycle that status bit 5 takes a new value. It does not go high when the VBUS input is re-applied at the value already stored.
- R4: When the synchronized session level becomes active, status bit 6 (session valid) is set and bit 7 (session end) is cleared. When it becomes inactive, bit 6 is cleared and bit 7 is set. Both bits stay zero until the first session change after reset. Updates take the same three-edge latency as R2, and bits 6 and 7 are never both set.
- R5: A change of the session input alone never raises the change pulse.
- R6: Every status bit other than 5, 6 and 7 reads as zero, including ID status bit 3.
- R7: A high read strobe at a rising edge loads the current status word into the read-data output, where it is visible from the next cycle. While the strobe is low, the read data holds its value even if the status word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vbus_lvl_i | input | 1 | VBUS-valid level from the USB core (asynchronous) |
| sess_lvl_i | input | 1 | Session-active level from the USB core (asynchronous) |
| rd_stb_i | input | 1 | Read strobe for the status register port |
| stat_o | output | 16 | Live OTG status word |
| rd_data_o | output | 16 | Status snapshot captured by the last read strobe |
| vbus_chg_o | output | 1 | One-cycle pulse that sets the VBUS-sense-change interrupt bit |

## Verification
The assertions assume several things about the inputs:
- Reset is asserted from time zero.
- Each level input is held for longer than the synchronizer depth plus one cycle, so every change reaches the status register as one clean step.
- The read strobe is a synchronous signal.

The bench drives inputs only just after falling edges. It holds every input pair for several cycles before the next change, and it sweeps all sixteen transitions between the four VBUS and session combinations. This includes the transitions where a level is re-applied unchanged. Reads are issued only once the status word has settled, and the hold check is made while the status word is changing.

// File: rtl/otg_stat_pkg.sv
package otg_stat_pkg;
  localparam int STAT_W     = 16;
  localparam int VBUS_POS   = 5;
  localparam int SVALID_POS = 6;
  localparam int SEND_POS   = 7;
  localparam int ID_POS     = 3;
  localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/otg_lvl_sync.sv
module otg_lvl_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] stg_d;
      if (g == 0) begin : g_first
        always_comb stg_d = async_i;
      end else begin : g_next
        always_comb stg_d = stg_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_d;
      end
    end
  endgenerate

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/otg_vbus_track.sv
module otg_vbus_track (
  input  logic clk,
  input  logic rst_n,
  input  logic vbus_s,
  output logic vbus_valid,
  output logic chg_pulse
);
  logic vbus_d, chg_d, vbus_q, chg_q;

  always_comb begin
    vbus_d = vbus_q;
    chg_d  = 1'b0;
    if (vbus_s != vbus_q) begin
      vbus_d = vbus_s;
      chg_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbus_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      vbus_q <= vbus_d;
      chg_q  <= chg_d;
    end
  end

  assign vbus_valid = vbus_q;
  assign chg_pulse  = chg_q;

  AST_PULSE_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> (vbus_q != $past(vbus_q))); // R3
  AST_CHANGE_MEANS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (vbus_q != $past(vbus_q)) |-> chg_q); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |=> !chg_q); // R3
endmodule

// File: rtl/otg_sess_track.sv
module otg_sess_track (
  input  logic clk,
  input  logic rst_n,
  input  logic sess_s,
  output logic sess_valid,
  output logic sess_end
);
  logic prev_q, valid_q, end_q;
  logic valid_d, end_d, upd;

  always_comb begin
    upd     = sess_s ^ prev_q;
    valid_d = valid_q;
    end_d   = end_q;
    if (upd) begin
      valid_d = sess_s;
      end_d   = ~sess_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      valid_q <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      prev_q <= sess_s;
      if (upd) begin
        valid_q <= valid_d;
        end_q   <= end_d;
      end
    end
  end

  assign sess_valid = valid_q;
  assign sess_end   = end_q;

  AST_SESS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({end_q, valid_q})); // R4
  AST_SESS_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q != $past(valid_q)) |-> (valid_q == $past(sess_s))); // R4
endmodule

// File: rtl/otg_status_tracker.sv
module otg_status_tracker
  import otg_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vbus_lvl_i,
  input  logic              sess_lvl_i,
  input  logic              rd_stb_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [STAT_W-1:0] rd_data_o,
  output logic              vbus_chg_o
);
  logic [1:0] lvl_s;
  logic vbus_bit, sess_v_bit, sess_e_bit, chg;
  logic [STAT_W-1:0] stat_w, rd_d, rd_q;

  otg_lvl_sync #(.W(2), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({sess_lvl_i, vbus_lvl_i}), .sync_o(lvl_s));

  otg_vbus_track u_vbus (
    .clk(clk), .rst_n(rst_n), .vbus_s(lvl_s[0]),
    .vbus_valid(vbus_bit), .chg_pulse(chg));

  otg_sess_track u_sess (
    .clk(clk), .rst_n(rst_n), .sess_s(lvl_s[1]),
    .sess_valid(sess_v_bit), .sess_end(sess_e_bit));

  always_comb begin
    stat_w             = '0;
    stat_w[ID_POS]     = 1'b0;
    stat_w[VBUS_POS]   = vbus_bit;
    stat_w[SVALID_POS] = sess_v_bit;
    stat_w[SEND_POS]   = sess_e_bit;
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_stb_i) rd_d = stat_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign stat_o     = stat_w;
  assign rd_data_o  = rd_q;
  assign vbus_chg_o = chg;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_stb_i) |-> $stable(rd_q)); // R7
  AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_stb_i) |-> (rd_q == $past(stat_w))); // R7
  AST_SESS_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((sess_v_bit != $past(sess_v_bit)) && $stable(vbus_bit)) |-> !chg); // R5
endmodule

// File: tb/otg_status_tracker_bench.sv
module otg_status_tracker_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, vbus, sess, rd_stb;
  logic [15:0] stat, rd_data;
  logic chg;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic m_v, m_sv, m_se, m_prev;
  logic [15:0] last_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  otg_status_tracker u_otg_status_tracker (
    .clk(clk), .rst_n(rst_n), .vbus_lvl_i(vbus), .sess_lvl_i(sess),
    .rd_stb_i(rd_stb), .stat_o(stat), .rd_data_o(rd_data), .vbus_chg_o(chg));

  function automatic logic [15:0] model_word(logic v, logic sv, logic se);
    return (16'(v) << 5) | (16'(sv) << 6) | (16'(se) << 7);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic nv, logic ns);
    logic [15:0] old_w, new_w;
    logic vchg;
    old_w = model_word(m_v, m_sv, m_se);
    vchg  = (nv != m_v);
    if (ns != m_prev) begin
      m_sv = ns;
      m_se = ~ns;
    end
    m_prev = ns;
    m_v    = nv;
    new_w  = model_word(m_v, m_sv, m_se);
    vbus = nv;
    sess = ns;
    @(negedge clk);
    check("R2 status before latency", stat, old_w);
    check("R5 no pulse early", {15'b0, chg}, 16'h0);
    @(negedge clk);
    check("R4 status before latency", stat, old_w);
    check("R3 no pulse early", {15'b0, chg}, 16'h0);
    @(negedge clk);
    check("R2 R4 R6 status updated", stat, new_w);
    check("R3 R5 pulse on vbus change only", {15'b0, chg}, {15'b0, vchg});
    check("R7 hold without strobe", rd_data, last_rd);
    @(negedge clk);
    check("R3 pulse single cycle", {15'b0, chg}, 16'h0);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    check("R7 read capture", rd_data, new_w);
    last_rd = new_w;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; vbus = 1'b0; sess = 1'b0; rd_stb = 1'b0;
    m_v = 0; m_sv = 0; m_se = 0; m_prev = 0; last_rd = '0;
    repeat (3) @(negedge clk);
    check("R1 status in reset", stat, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status after reset", stat, 16'h0);
    check("R1 pulse after reset", {15'b0, chg}, 16'h0);
    check("R1 read data after reset", rd_data, 16'h0);
    check("R6 id bit zero", {15'b0, stat[3]}, 16'h0);
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        apply(a[0], a[1]);
        apply(b[0], b[1]);
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule